// File: doc/BRIEF.md
# Serial Receive Buffer with Overflow Policy

This block is the receive-side buffering of a serial peripheral. A frame-complete strobe delivers one received word per frame; the word lands first in a one-word holding stage and, on the following clock, moves into a small first-in first-out queue if there is room. The host drains the queue through a valid/ready read port. When the queue and the holding stage are both occupied and another frame completes, the block records an overflow. A policy bit then decides whether the new word replaces the held word or is thrown away.

Two request lines tell the host about the buffer. The first is a sticky overflow indication with its own interrupt enable. The second is a drain request that is raised while the queue holds data. A select bit routes the drain request to either a DMA request pin or an interrupt pin.

The frame input cannot be stalled. A serial link keeps shifting whatever the state of the buffer, so there is no ready signal on that side, and the overflow policy is how pressure from the reader is resolved. On the read side, `rd_valid` is high whenever the queue holds a word. `rd_data` shows the oldest word. A word is removed on each clock edge at which `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, the head word and `rd_valid` do not change.

Top module: `serrx_buffer`

## Requirements
- R1: After reset, `rd_valid`, `fifo_full`, `hold_full`, `ovf_flag`, `ovf_irq`, `drain_irq` and `drain_dma` are all 0.
- R2: A word strobed in with `frm_valid` shows as `hold_full`=1 after the next clock edge. One edge later it enters the queue if there is room. Words leave the queue in arrival order.
- R3: An overflow is recorded only when a frame completes while the queue is full, the holding stage is full and no pop happens in that cycle. `ovf_flag` is 1 after that clock edge.
- R4: If a pop occurs in the same cycle as a frame arrives with the queue and holding stage both full, no overflow is recorded and no word is lost.
- R5: With `cfg_overwrite`=1, the word of an overflowing frame replaces the word in the holding stage.
- R6: With `cfg_overwrite`=0, the word of an overflowing frame is discarded and the holding stage keeps its word.
- R7: `ovf_flag` stays 1 until a cycle with `ovf_clr`=1 clears it. If an overflow and `ovf_clr` fall in the same cycle, the flag ends up 1.
- R8: `ovf_irq` is 1 exactly when `ovf_flag`=1 and `cfg_ovf_irq_en`=1. The flag is set regardless of the enable.
- R9: The drain request is active only while the queue is non-empty and `cfg_drain_en`=1.
- R10: An active drain request appears on `drain_dma` when `cfg_drain_dma`=1 and on `drain_irq` when `cfg_drain_dma`=0. The two are never 1 together.
- R11: While `rd_valid`=1 and `rd_ready`=0, `rd_valid` stays 1 and `rd_data` holds its value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Frame-complete strobe, one cycle per word |
| frm_data | input | W | Received word |
| rd_valid | output | 1 | Queue holds a word |
| rd_ready | input | 1 | Reader accepts the head word |
| rd_data | output | W | Oldest word in the queue |
| cfg_overwrite | input | 1 | 1: overflowing word replaces the held word; 0: it is discarded |
| cfg_ovf_irq_en | input | 1 | Enables the overflow interrupt |
| cfg_drain_en | input | 1 | Enables the drain request |
| cfg_drain_dma | input | 1 | 1: drain request goes to DMA; 0: to the interrupt |
| ovf_clr | input | 1 | Write-one-to-clear pulse for the overflow flag |
| ovf_flag | output | 1 | Sticky overflow status |
| ovf_irq | output | 1 | Overflow interrupt |
| drain_irq | output | 1 | Drain request as interrupt |
| drain_dma | output | 1 | Drain request as DMA request |
| fifo_full | output | 1 | Queue full |
| hold_full | output | 1 | Holding stage occupied |

## Verification
The bench fills the queue and the holding stage, then sends one more frame and drains everything. The last word read reveals the policy: a design with the policy inverted, or one that overwrites a queue slot, returns the wrong final word. It also sends a frame in the same cycle as a pop on a full buffer. A design that checks only for fullness and ignores the pop flags a false overflow and drops a word. Further tests clear the flag in the same cycle as a new overflow, and sweep the drain routing and enables. A wrong set/clear priority leaves the flag low, and a routing fault raises both request pins or the wrong one.

// File: rtl/serrx_pkg.sv
package serrx_pkg;
  // Destination of the drain request
  typedef enum logic { DRAIN_TO_IRQ = 1'b0, DRAIN_TO_DMA = 1'b1 } drain_route_e;

  // Action taken on the holding stage in a given cycle
  typedef enum logic [1:0] {
    HOLD_IDLE  = 2'd0,
    HOLD_LOAD  = 2'd1,
    HOLD_DRAIN = 2'd2,
    HOLD_KEEP  = 2'd3
  } hold_act_e;
endpackage

// File: rtl/serrx_fifo.sv
module serrx_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CMAX);
  assign head  = mem[rptr];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n)                               mem[gi] <= '0;
        else if (push && (wptr == AW'(gi)))       mem[gi] <= push_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4: the queue is never written while full unless a word leaves in the same cycle
  assert_no_push_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);
  // R11: nothing is removed from an empty queue
  assert_no_pop_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/serrx_hold.sv
module serrx_hold
  import serrx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frm_valid,
  input  logic [W-1:0] frm_data,
  input  logic         room,
  input  logic         overwrite,
  output logic         hold_vld,
  output logic [W-1:0] hold_data,
  output logic         xfer,
  output logic         ovf_event
);
  hold_act_e act;

  assign xfer      = hold_vld && room;
  assign ovf_event = frm_valid && hold_vld && !room;

  always_comb begin
    if (frm_valid && (!ovf_event || overwrite)) act = HOLD_LOAD;
    else if (ovf_event)                         act = HOLD_KEEP;
    else if (xfer)                              act = HOLD_DRAIN;
    else                                        act = HOLD_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_data <= '0;
    end else begin
      case (act)
        HOLD_LOAD: begin
          hold_vld  <= 1'b1;
          hold_data <= frm_data;
        end
        HOLD_DRAIN: hold_vld <= 1'b0;
        default:    ;
      endcase
    end
  end

  // R5: an overflowing word replaces the held word under the overwrite policy
  assert_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_event && overwrite) |=> (hold_vld && hold_data == $past(frm_data)));
  // R6: an overflowing word is dropped under the discard policy
  assert_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_event && !overwrite) |=> (hold_vld && $stable(hold_data)));
  // R2: a frame always leaves the holding stage occupied
  assert_frame_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> hold_vld);
endmodule

// File: rtl/serrx_req.sv
module serrx_req
  import serrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_event,
  input  logic ovf_clr,
  input  logic ovf_irq_en,
  input  logic not_empty,
  input  logic drain_en,
  input  logic drain_dma_sel,
  output logic ovf_flag,
  output logic ovf_irq,
  output logic drain_irq,
  output logic drain_dma
);
  drain_route_e route;
  logic         drain_req;

  assign route     = drain_route_e'(drain_dma_sel);
  assign drain_req = not_empty && drain_en;
  assign drain_dma = drain_req && (route == DRAIN_TO_DMA);
  assign drain_irq = drain_req && (route == DRAIN_TO_IRQ);
  assign ovf_irq   = ovf_flag && ovf_irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n)         ovf_flag <= 1'b0;
    else if (ovf_event) ovf_flag <= 1'b1;
    else if (ovf_clr)   ovf_flag <= 1'b0;
  end

  // R10: the drain request never appears on both pins
  assert_one_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(drain_irq && drain_dma));
  // R7: the flag only drops after a clear pulse
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  // R7: an overflow wins over a simultaneous clear
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> ovf_flag);
endmodule

// File: rtl/serrx_buffer.sv
module serrx_buffer
  import serrx_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frm_valid,
  input  logic [W-1:0] frm_data,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data,
  input  logic         cfg_overwrite,
  input  logic         cfg_ovf_irq_en,
  input  logic         cfg_drain_en,
  input  logic         cfg_drain_dma,
  input  logic         ovf_clr,
  output logic         ovf_flag,
  output logic         ovf_irq,
  output logic         drain_irq,
  output logic         drain_dma,
  output logic         fifo_full,
  output logic         hold_full
);
  logic         pop, empty, full, room, xfer, ovf_event, hold_vld;
  logic [W-1:0] hold_data;

  assign rd_valid  = !empty;
  assign pop       = rd_valid && rd_ready;
  assign room      = !full || pop;
  assign fifo_full = full;
  assign hold_full = hold_vld;

  serrx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(xfer), .push_data(hold_data), .pop(pop),
    .head(rd_data), .empty(empty), .full(full)
  );

  serrx_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_data(frm_data),
    .room(room), .overwrite(cfg_overwrite),
    .hold_vld(hold_vld), .hold_data(hold_data),
    .xfer(xfer), .ovf_event(ovf_event)
  );

  serrx_req u_req (
    .clk(clk), .rst_n(rst_n),
    .ovf_event(ovf_event), .ovf_clr(ovf_clr), .ovf_irq_en(cfg_ovf_irq_en),
    .not_empty(rd_valid), .drain_en(cfg_drain_en), .drain_dma_sel(cfg_drain_dma),
    .ovf_flag(ovf_flag), .ovf_irq(ovf_irq),
    .drain_irq(drain_irq), .drain_dma(drain_dma)
  );

  // R11: a stalled head word stays put
  assert_head_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R3: the flag rises only after a frame met a full queue, a full holding stage and no pop
  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(frm_valid && fifo_full && hold_full && !pop));
endmodule

// File: tb/tb_serrx_buffer.sv
`timescale 1ns/1ps
module tb_serrx_buffer;
  localparam int W = 16;
  localparam int DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic frm_valid = 0, rd_ready = 0, ovf_clr = 0;
  logic [W-1:0] frm_data = '0;
  logic cfg_overwrite = 0, cfg_ovf_irq_en = 0, cfg_drain_en = 0, cfg_drain_dma = 0;
  logic rd_valid, ovf_flag, ovf_irq, drain_irq, drain_dma, fifo_full, hold_full;
  logic [W-1:0] rd_data;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serrx_buffer #(.W(W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .cfg_overwrite(cfg_overwrite), .cfg_ovf_irq_en(cfg_ovf_irq_en),
    .cfg_drain_en(cfg_drain_en), .cfg_drain_dma(cfg_drain_dma),
    .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq),
    .drain_irq(drain_irq), .drain_dma(drain_dma),
    .fifo_full(fifo_full), .hold_full(hold_full)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One frame; clear and pop may be driven in the same cycle
  task automatic send(input logic [W-1:0] d, input bit clr = 0, input bit rdy = 0);
    @(negedge clk);
    frm_valid = 1; frm_data = d; ovf_clr = clr; rd_ready = rdy;
    @(negedge clk);
    frm_valid = 0; ovf_clr = 0; rd_ready = 0;
  endtask

  task automatic pop_expect(input logic [W-1:0] exp, input string req);
    @(negedge clk);
    chk({req, " rd_valid"}, 32'(rd_valid), 1);
    chk({req, " rd_data"}, 32'(rd_data), 32'(exp));
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
  endtask

  // Queue full plus one word held: base, base+1, ..., base+DEPTH
  task automatic fill(input logic [W-1:0] base);
    for (int i = 0; i <= DEPTH; i++) begin
      send(base + W'(i));
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 rd_valid", 32'(rd_valid), 0);
    chk("R1 ovf_flag", 32'(ovf_flag), 0);
    chk("R1 ovf_irq", 32'(ovf_irq), 0);
    chk("R1 drain", 32'({drain_irq, drain_dma}), 0);
    chk("R1 full", 32'({fifo_full, hold_full}), 0);
  endtask

  task automatic t_order();
    send(16'h1111);
    chk("R2 hold after one edge", 32'(hold_full), 1);
    chk("R2 not yet in queue", 32'(rd_valid), 0);
    @(negedge clk);
    chk("R2 in queue", 32'(rd_valid), 1);
    chk("R2 hold freed", 32'(hold_full), 0);
    send(16'h2222); send(16'h3333);
    repeat (2) @(negedge clk);
    chk("R11 head while stalled", 32'(rd_data), 32'h1111);
    @(negedge clk);
    chk("R11 head still stalled", 32'(rd_data), 32'h1111);
    pop_expect(16'h1111, "R2 order");
    pop_expect(16'h2222, "R2 order");
    pop_expect(16'h3333, "R2 order");
    @(negedge clk);
    chk("R2 empty", 32'(rd_valid), 0);
  endtask

  task automatic t_drain_route();
    @(negedge clk); cfg_drain_en = 1; cfg_drain_dma = 0;
    @(negedge clk);
    chk("R9 empty no request", 32'({drain_irq, drain_dma}), 0);
    send(16'hA5A5); @(negedge clk);
    chk("R10 irq route", 32'({drain_irq, drain_dma}), 32'b10);
    cfg_drain_dma = 1; #1;
    chk("R10 dma route", 32'({drain_irq, drain_dma}), 32'b01);
    cfg_drain_en = 0; #1;
    chk("R9 disabled", 32'({drain_irq, drain_dma}), 0);
    pop_expect(16'hA5A5, "R9 drain");
    cfg_drain_dma = 0;
  endtask

  task automatic t_ovf_discard();
    cfg_overwrite = 0; cfg_ovf_irq_en = 0;
    fill(16'h0100);
    chk("R3 both full", 32'({fifo_full, hold_full}), 32'b11);
    chk("R3 no flag yet", 32'(ovf_flag), 0);
    send(16'h0DEF);
    chk("R3 flag set", 32'(ovf_flag), 1);
    chk("R8 irq masked", 32'(ovf_irq), 0);
    repeat (3) @(negedge clk);
    chk("R7 sticky", 32'(ovf_flag), 1);
    for (int i = 0; i <= DEPTH; i++) pop_expect(16'h0100 + W'(i), "R6 discard");
    @(negedge clk);
    chk("R6 nothing more", 32'(rd_valid), 0);
    clear_flag();
    chk("R7 cleared", 32'(ovf_flag), 0);
  endtask

  task automatic t_ovf_overwrite();
    cfg_overwrite = 1; cfg_ovf_irq_en = 1;
    fill(16'h0200);
    send(16'h0BEE);
    chk("R8 irq enabled", 32'(ovf_irq), 1);
    send(16'h0CAB, 1);
    chk("R7 set wins over clear", 32'(ovf_flag), 1);
    for (int i = 0; i < DEPTH; i++) pop_expect(16'h0200 + W'(i), "R5 queue kept");
    pop_expect(16'h0CAB, "R5 overwrite");
    clear_flag();
    chk("R8 irq drops", 32'(ovf_irq), 0);
    cfg_overwrite = 0; cfg_ovf_irq_en = 0;
  endtask

  task automatic t_pop_push();
    fill(16'h0300);
    send(16'h0399, 0, 1);
    chk("R4 no overflow", 32'(ovf_flag), 0);
    @(negedge clk);
    for (int i = 1; i <= DEPTH; i++) pop_expect(16'h0300 + W'(i), "R4 no loss");
    pop_expect(16'h0399, "R4 new word kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_drain_route();
    t_ovf_discard();
    t_ovf_overwrite();
    t_pop_push();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule